// File: doc/BRIEF.md
# UART Modem Control and Diagnostic Loopback

This block holds the modem control word of a UART and turns it into the active-low modem handshake pins, the serial transmit pin and the infrared transmit pin. Software reaches the word through a simple register bus: one select, one write strobe, an address and a 32-bit data word. The word sits at a fixed offset. Reads are combinational, and writes land on the clock edge that samples the strobe.

Loopback mode exists for self-test. In that mode the outputs to the outside world are parked. The modem control bits reach the UART's status inputs directly. The transmit stream goes back into the receive path: unchanged for plain serial signalling, inverted for infrared signalling.

Automatic flow control lets the receive FIFO hold off the far end. The request-to-send line is pulled inactive while the FIFO fill is above its trigger level. The loopback path sees the same gating, so the throttling can be tested without a cable.

Top module: `modem_ctrl_loop`

## Requirements
- R1: After reset the control word reads 0, all four modem output pins are high, soutPin follows txSerial and irOutPin follows irTxData.
- R2: Bits [6:0] of the word hold the fields (bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 loopback, bit5 auto-flow enable, bit6 infrared mode). Bits [31:7] always read 0. A write whose address differs from REG_OFFSET (default 0x10) changes nothing.
- R3: With loopback off, dtrPinN, rtsPinN, out1PinN and out2PinN are the inverse of the DTR, RTS, OUT1 and OUT2 bits.
- R4: With loopback on, all four modem output pins are high. The status outputs are the inverted control bits: DTR to dsrStatN, RTS to ctsStatN, OUT1 to riStatN, OUT2 to dcdStatN.
- R5: With loopback on, the external status pins dsrPinN, ctsPinN, riPinN and dcdPinN have no effect on the status outputs.
- R6: With loopback on and infrared mode off, soutPin is 1 and rxSerial equals txSerial. irOutPin is 0.
- R7: With loopback on and infrared mode on, irOutPin is 0, irRxData equals the inverse of irTxData, soutPin is 1 and rxSerial follows sinPin.
- R8: The infrared bit can be set only when SIR_EN=1, and the auto-flow bit only when AFC_EN=1. Otherwise each reads 0 and ignores writes.
- R9: When auto-flow, fifoEnable and rxAboveThr are all 1 and RTS is 1, rtsPinN is high. When either flag is 0 and RTS is 1, rtsPinN is low.
- R10: With RTS=0, rtsPinN is high (loopback off) and ctsStatN is high (loopback on), whatever the FIFO flags are.
- R11: In loopback, ctsStatN carries the RTS value after auto-flow gating.
- R12: A write takes effect on the rising edge that samples the strobe. Before that edge the outputs keep their old values.
- R13: With loopback off, each status output equals its external pin, rxSerial equals sinPin and irRxData equals irInPin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | Bus access select |
| regWrite | input | 1 | Write strobe, qualified by regSel |
| regAddr | input | ADDR_W | Byte address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, 0 when not addressed |
| fifoEnable | input | 1 | FIFOs enabled |
| rxAboveThr | input | 1 | Receive FIFO above trigger level |
| dsrPinN | input | 1 | External data-set-ready pin |
| ctsPinN | input | 1 | External clear-to-send pin |
| riPinN | input | 1 | External ring indicator pin |
| dcdPinN | input | 1 | External carrier detect pin |
| dtrPinN | output | 1 | Terminal ready pin |
| rtsPinN | output | 1 | Request to send pin |
| out1PinN | output | 1 | User output 1 pin |
| out2PinN | output | 1 | User output 2 pin |
| dsrStatN | output | 1 | Data-set-ready seen by the UART |
| ctsStatN | output | 1 | Clear-to-send seen by the UART |
| riStatN | output | 1 | Ring indicator seen by the UART |
| dcdStatN | output | 1 | Carrier detect seen by the UART |
| txSerial | input | 1 | Serial transmit stream |
| soutPin | output | 1 | Serial output pin |
| sinPin | input | 1 | Serial input pin |
| rxSerial | output | 1 | Serial receive stream to the UART |
| irTxData | input | 1 | Infrared transmit stream |
| irOutPin | output | 1 | Infrared output pin |
| irInPin | input | 1 | Infrared input pin |
| irRxData | output | 1 | Infrared receive stream to the UART |

## Verification
The control word is the only state. A write is visible on the read port and on every pin one rising edge after the strobe is presented. The routing from the FIFO flags, the status pins and the serial lines to the outputs is combinational, so a changed input shows in the same cycle. The bench drives all inputs on the falling edge. It checks a write's result at the next falling edge, after the sampling edge. It also checks that nothing moved a moment after driving the strobe, before that edge. Checks on combinational paths are sampled one time step after the input changes.

// File: rtl/modem_ctrl_pkg.sv
package modem_ctrl_pkg;
  localparam int FIELD_W = 7;
  localparam int LINE_N  = 4;

  typedef struct packed {
    logic sire;
    logic afce;
    logic loopOn;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mcrBits_t;

  typedef struct packed {
    logic loopOn;
    logic uartLoop;
    logic irLoop;
    logic autoGate;
  } routeCtl_t;
endpackage

// File: rtl/modem_ctrl_regs.sv
module modem_ctrl_regs
  import modem_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10,
  parameter bit SIR_EN = 1'b1,
  parameter bit AFC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              fifoEnable,
  output mcrBits_t          mcrQ,
  output routeCtl_t         routeCtl
);
  localparam logic [DATA_W-1:0] BASE_MASK = DATA_W'(5'h1f);
  localparam logic [DATA_W-1:0] AFC_MASK  = AFC_EN ? DATA_W'(7'h20) : '0;
  localparam logic [DATA_W-1:0] SIR_MASK  = SIR_EN ? DATA_W'(7'h40) : '0;
  localparam logic [DATA_W-1:0] WR_MASK   = BASE_MASK | AFC_MASK | SIR_MASK;

  logic [DATA_W-1:0] wordQ;
  logic              addrHit;
  logic              wrHit;

  assign addrHit = regSel && (regAddr == REG_OFFSET);
  assign wrHit   = addrHit && regWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (wrHit) begin
      wordQ <= (wordQ & ~WR_MASK) | (regWdata & WR_MASK);
    end
  end

  assign regRdata = addrHit ? wordQ : '0;
  assign mcrQ     = mcrBits_t'(wordQ[FIELD_W-1:0]);

  always_comb begin
    routeCtl.loopOn   = mcrQ.loopOn;
    routeCtl.uartLoop = mcrQ.loopOn && !mcrQ.sire;
    routeCtl.irLoop   = mcrQ.loopOn && mcrQ.sire;
    routeCtl.autoGate = mcrQ.afce && fifoEnable;
  end
endmodule

// File: rtl/modem_ctrl_route.sv
module modem_ctrl_route
  import modem_ctrl_pkg::*;
(
  input  mcrBits_t            mcrQ,
  input  routeCtl_t           routeCtl,
  input  logic                rxAboveThr,
  input  logic [LINE_N-1:0]   extStatN,
  output logic [LINE_N-1:0]   pinOutN,
  output logic [LINE_N-1:0]   statN,
  input  logic                txSerial,
  output logic                soutPin,
  input  logic                sinPin,
  output logic                rxSerial,
  input  logic                irTxData,
  output logic                irOutPin,
  input  logic                irInPin,
  output logic                irRxData
);
  logic              rtsEff;
  logic [LINE_N-1:0] drvBit;

  assign rtsEff = mcrQ.rts && !(routeCtl.autoGate && rxAboveThr);
  assign drvBit = {mcrQ.out2, mcrQ.out1, rtsEff, mcrQ.dtr};

  for (genvar i = 0; i < LINE_N; i++) begin : g_line
    assign pinOutN[i] = routeCtl.loopOn ? 1'b1 : ~drvBit[i];
    assign statN[i]   = routeCtl.loopOn ? ~drvBit[i] : extStatN[i];
  end

  assign soutPin  = routeCtl.loopOn ? 1'b1 : txSerial;
  assign rxSerial = routeCtl.uartLoop ? txSerial : sinPin;
  assign irOutPin = routeCtl.loopOn ? 1'b0 : irTxData;
  assign irRxData = routeCtl.irLoop ? ~irTxData : irInPin;
endmodule

// File: rtl/modem_ctrl_loop.sv
module modem_ctrl_loop
  import modem_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10,
  parameter bit SIR_EN = 1'b1,
  parameter bit AFC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              fifoEnable,
  input  logic              rxAboveThr,
  input  logic              dsrPinN,
  input  logic              ctsPinN,
  input  logic              riPinN,
  input  logic              dcdPinN,
  output logic              dtrPinN,
  output logic              rtsPinN,
  output logic              out1PinN,
  output logic              out2PinN,
  output logic              dsrStatN,
  output logic              ctsStatN,
  output logic              riStatN,
  output logic              dcdStatN,
  input  logic              txSerial,
  output logic              soutPin,
  input  logic              sinPin,
  output logic              rxSerial,
  input  logic              irTxData,
  output logic              irOutPin,
  input  logic              irInPin,
  output logic              irRxData
);
  mcrBits_t          mcrQ;
  routeCtl_t         routeCtl;
  logic [LINE_N-1:0] pinOutN;
  logic [LINE_N-1:0] statN;

  modem_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET),
    .SIR_EN(SIR_EN), .AFC_EN(AFC_EN)
  ) u_regs (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .fifoEnable(fifoEnable), .mcrQ(mcrQ), .routeCtl(routeCtl)
  );

  modem_ctrl_route u_route (
    .mcrQ(mcrQ), .routeCtl(routeCtl), .rxAboveThr(rxAboveThr),
    .extStatN({dcdPinN, riPinN, ctsPinN, dsrPinN}),
    .pinOutN(pinOutN), .statN(statN),
    .txSerial(txSerial), .soutPin(soutPin), .sinPin(sinPin), .rxSerial(rxSerial),
    .irTxData(irTxData), .irOutPin(irOutPin), .irInPin(irInPin), .irRxData(irRxData)
  );

  assign {out2PinN, out1PinN, rtsPinN, dtrPinN}   = pinOutN;
  assign {dcdStatN, riStatN, ctsStatN, dsrStatN} = statN;
endmodule

// File: rtl/modem_ctrl_loop_chk.sv
module modem_ctrl_loop_chk
  import modem_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10,
  parameter bit SIR_EN = 1'b1,
  parameter bit AFC_EN = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              regSel,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              fifoEnable,
  input logic              rxAboveThr,
  input mcrBits_t          mcrQ,
  input logic              dtrPinN,
  input logic              rtsPinN,
  input logic              out1PinN,
  input logic              out2PinN,
  input logic              soutPin,
  input logic              txSerial,
  input logic              rxSerial,
  input logic              irOutPin,
  input logic              irTxData,
  input logic              irRxData
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:FIELD_W] == '0);

  p_write_lands_r12: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regWrite && regAddr == REG_OFFSET)
    |=> (mcrQ.dtr == $past(regWdata[0])) && (mcrQ.loopOn == $past(regWdata[4])));

  p_pins_parked_r4: assert property (@(posedge clk) disable iff (!rstN)
    mcrQ.loopOn |-> (dtrPinN && rtsPinN && out1PinN && out2PinN && soutPin && !irOutPin));

  p_uart_loop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mcrQ.loopOn && !mcrQ.sire) |-> (rxSerial == txSerial));

  p_ir_loop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mcrQ.loopOn && mcrQ.sire) |-> (irRxData == !irTxData));

  p_feature_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!(SIR_EN) |-> !mcrQ.sire) and (!(AFC_EN) |-> !mcrQ.afce));

  p_auto_rts_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mcrQ.afce && fifoEnable && rxAboveThr) |-> rtsPinN);

  p_rts_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    !mcrQ.rts |-> rtsPinN);
endmodule

bind modem_ctrl_loop modem_ctrl_loop_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET),
  .SIR_EN(SIR_EN), .AFC_EN(AFC_EN)
) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
  .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
  .fifoEnable(fifoEnable), .rxAboveThr(rxAboveThr), .mcrQ(mcrQ),
  .dtrPinN(dtrPinN), .rtsPinN(rtsPinN), .out1PinN(out1PinN), .out2PinN(out2PinN),
  .soutPin(soutPin), .txSerial(txSerial), .rxSerial(rxSerial),
  .irOutPin(irOutPin), .irTxData(irTxData), .irRxData(irRxData)
);

// File: tb/test_modem_ctrl_loop.sv
`timescale 1ns/1ps
module test_modem_ctrl_loop;
  localparam logic [7:0] OFF = 8'h10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, regWrite = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata, bRdata;
  logic fifoEnable = 1'b0, rxAboveThr = 1'b0;
  logic dsrPinN = 1'b1, ctsPinN = 1'b1, riPinN = 1'b1, dcdPinN = 1'b1;
  logic txSerial = 1'b1, sinPin = 1'b1, irTxData = 1'b0, irInPin = 1'b0;
  logic dtrPinN, rtsPinN, out1PinN, out2PinN;
  logic dsrStatN, ctsStatN, riStatN, dcdStatN;
  logic soutPin, rxSerial, irOutPin, irRxData;
  logic [3:0] bPins, bStat;
  logic [3:0] bSer;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  modem_ctrl_loop i_modem_ctrl_loop (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .fifoEnable(fifoEnable), .rxAboveThr(rxAboveThr),
    .dsrPinN(dsrPinN), .ctsPinN(ctsPinN), .riPinN(riPinN), .dcdPinN(dcdPinN),
    .dtrPinN(dtrPinN), .rtsPinN(rtsPinN), .out1PinN(out1PinN), .out2PinN(out2PinN),
    .dsrStatN(dsrStatN), .ctsStatN(ctsStatN), .riStatN(riStatN), .dcdStatN(dcdStatN),
    .txSerial(txSerial), .soutPin(soutPin), .sinPin(sinPin), .rxSerial(rxSerial),
    .irTxData(irTxData), .irOutPin(irOutPin), .irInPin(irInPin), .irRxData(irRxData)
  );

  modem_ctrl_loop #(.SIR_EN(1'b0), .AFC_EN(1'b0)) i_modem_ctrl_loop_bare (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(bRdata),
    .fifoEnable(fifoEnable), .rxAboveThr(rxAboveThr),
    .dsrPinN(dsrPinN), .ctsPinN(ctsPinN), .riPinN(riPinN), .dcdPinN(dcdPinN),
    .dtrPinN(bPins[0]), .rtsPinN(bPins[1]), .out1PinN(bPins[2]), .out2PinN(bPins[3]),
    .dsrStatN(bStat[0]), .ctsStatN(bStat[1]), .riStatN(bStat[2]), .dcdStatN(bStat[3]),
    .txSerial(txSerial), .soutPin(bSer[0]), .sinPin(sinPin), .rxSerial(bSer[1]),
    .irTxData(irTxData), .irOutPin(bSer[2]), .irInPin(irInPin), .irRxData(bSer[3])
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] bd);
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b0; regAddr = a;
    #1 d = regRdata; bd = bRdata;
    regSel = 1'b0;
  endtask

  function automatic logic [3:0] pins();
    return {out2PinN, out1PinN, rtsPinN, dtrPinN};
  endfunction

  function automatic logic [3:0] stats();
    return {dcdStatN, riStatN, ctsStatN, dsrStatN};
  endfunction

  task automatic t_reset();
    logic [31:0] d, bd;
    rd(OFF, d, bd);
    chk("R1 reset word", d, 0);
    chk("R1 reset pins", 32'(pins()), 32'hf);
    txSerial = 1'b0; irTxData = 1'b1; #1;
    chk("R1 sout follows tx", 32'(soutPin), 0);
    chk("R1 irOut follows irTx", 32'(irOutPin), 1);
    txSerial = 1'b1; irTxData = 1'b0;
  endtask

  task automatic t_regs();
    logic [31:0] d, bd;
    wr(OFF, 32'hffff_ff80);
    rd(OFF, d, bd);
    chk("R2 reserved bits read 0", d, 0);
    wr(OFF, 32'h0000_000f);
    rd(OFF, d, bd);
    chk("R2 fields stored", d, 32'hf);
    wr(8'h14, 32'h0);
    rd(OFF, d, bd);
    chk("R2 other address ignored", d, 32'hf);
    rd(8'h14, d, bd);
    chk("R2 other address reads 0", d, 0);
    wr(OFF, 0);
  endtask

  task automatic t_pins();
    @(negedge clk);
    regSel = 1'b1; regWrite = 1'b1; regAddr = OFF; regWdata = 32'h5;
    #1 chk("R12 no change before edge", 32'(pins()), 32'hf);
    @(negedge clk);
    regSel = 1'b0; regWrite = 1'b0;
    chk("R12 change after edge", 32'(pins()), 32'ha);
    chk("R3 pins for 0x5", 32'(pins()), 32'ha);
    wr(OFF, 32'ha);
    chk("R3 pins for 0xa", 32'(pins()), 32'h5);
    wr(OFF, 0);
  endtask

  task automatic t_pass();
    {dcdPinN, riPinN, ctsPinN, dsrPinN} = 4'b0110;
    sinPin = 1'b0; irInPin = 1'b1; #1;
    chk("R13 status pass", 32'(stats()), 32'h6);
    chk("R13 rx pass", 32'({rxSerial, irRxData}), 32'h1);
    {dcdPinN, riPinN, ctsPinN, dsrPinN} = 4'b1001;
    sinPin = 1'b1; irInPin = 1'b0; #1;
    chk("R13 status pass 2", 32'(stats()), 32'h9);
    chk("R13 rx pass 2", 32'({rxSerial, irRxData}), 32'h2);
  endtask

  task automatic t_loop();
    wr(OFF, 32'h15);
    chk("R4 pins parked", 32'(pins()), 32'hf);
    chk("R4 looped status", 32'(stats()), 32'ha);
    {dcdPinN, riPinN, ctsPinN, dsrPinN} = 4'b0101; #1;
    chk("R5 external pins ignored", 32'(stats()), 32'ha);
    {dcdPinN, riPinN, ctsPinN, dsrPinN} = 4'b1010; #1;
    chk("R5 external pins ignored 2", 32'(stats()), 32'ha);
  endtask

  task automatic t_uartLoop();
    wr(OFF, 32'h10);
    sinPin = 1'b1; txSerial = 1'b0; #1;
    chk("R6 sout high", 32'(soutPin), 1);
    chk("R6 rx from tx 0", 32'(rxSerial), 0);
    chk("R6 irOut low", 32'(irOutPin), 0);
    sinPin = 1'b0; txSerial = 1'b1; #1;
    chk("R6 rx from tx 1", 32'(rxSerial), 1);
  endtask

  task automatic t_sirLoop();
    wr(OFF, 32'h50);
    irInPin = 1'b0; irTxData = 1'b0; sinPin = 1'b0; txSerial = 1'b1; #1;
    chk("R7 irOut low", 32'(irOutPin), 0);
    chk("R7 irRx inverted 0", 32'(irRxData), 1);
    chk("R7 sout high, rx from pin", 32'({soutPin, rxSerial}), 32'h2);
    irTxData = 1'b1; irInPin = 1'b1; #1;
    chk("R7 irRx inverted 1", 32'(irRxData), 0);
    irTxData = 1'b0; wr(OFF, 0);
  endtask

  task automatic t_autoRts();
    wr(OFF, 32'h22);
    fifoEnable = 1'b1; rxAboveThr = 1'b1; #1;
    chk("R9 above threshold", 32'(rtsPinN), 1);
    rxAboveThr = 1'b0; #1;
    chk("R9 below threshold", 32'(rtsPinN), 0);
    fifoEnable = 1'b0; rxAboveThr = 1'b1; #1;
    chk("R9 fifo disabled", 32'(rtsPinN), 0);
    wr(OFF, 32'h20);
    fifoEnable = 1'b1; rxAboveThr = 1'b0; #1;
    chk("R10 rts clear", 32'(rtsPinN), 1);
  endtask

  task automatic t_loopRts();
    wr(OFF, 32'h32);
    fifoEnable = 1'b1; rxAboveThr = 1'b1; #1;
    chk("R11 looped cts gated", 32'(ctsStatN), 1);
    chk("R11 rts pin parked", 32'(rtsPinN), 1);
    rxAboveThr = 1'b0; #1;
    chk("R11 looped cts open", 32'(ctsStatN), 0);
    wr(OFF, 32'h30);
    chk("R10 looped cts clear", 32'(ctsStatN), 1);
    wr(OFF, 0);
  endtask

  task automatic t_params();
    logic [31:0] d, bd;
    wr(OFF, 32'h7f);
    rd(OFF, d, bd);
    chk("R8 full word when enabled", d, 32'h7f);
    chk("R8 locked bits when disabled", bd, 32'h1f);
    wr(OFF, 32'h62);
    fifoEnable = 1'b1; rxAboveThr = 1'b1; #1;
    chk("R8 no gating without auto-flow", 32'(bPins[1]), 0);
    wr(OFF, 0);
    fifoEnable = 1'b0; rxAboveThr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_pins();
    t_pass();
    t_loop();
    t_uartLoop();
    t_sirLoop();
    t_autoRts();
    t_loopRts();
    t_params();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule